// File: doc/BRIEF.md
# Transceiver Transmitter Reset Sequencer

This block takes a serial transmitter out of reset after power-up and when later partial resets are requested. It drives four active-high reset outputs: one for the calibration engine, one that powers down the transmit PLL, one for the transmit analog section and one for the transmit digital section. It watches two status inputs that arrive asynchronously, PLL lock and calibration busy. Each is passed through a two-flop synchronizer before use. Each minimum hold time is a cycle-count parameter that is worked out from the controller clock frequency.

On power-up, or on the global asynchronous reset, the machine starts in `ST_RST_ALL` with all four resets asserted. It moves to `ST_SPLIT`, where one of the calibration reset and the PLL power-down has already been released and the other is still held. A parameter chooses which of the two goes first. Analog reset is released in the same cycle as PLL power-down. `ST_WAIT_GATE` keeps digital reset asserted until three conditions have held together for a programmable number of cycles: PLL power-down low, lock high and calibration busy low. If any of them drops, the count restarts, because lock can bounce while calibration runs. `ST_READY` is the operating state. A request for a PLL reset enters `ST_PLL_HOLD`. A request for an analog reset enters `ST_ANA_HOLD`. Both then go back through `ST_WAIT_GATE`. A digital-only request goes straight to `ST_WAIT_GATE`.

Transitions: `ST_RST_ALL`→`ST_SPLIT` when the first hold ends. `ST_SPLIT`→`ST_WAIT_GATE` when the second hold ends. `ST_WAIT_GATE`→`ST_READY` when the gate hold is met. `ST_READY`→`ST_PLL_HOLD`/`ST_ANA_HOLD`/`ST_WAIT_GATE` on req_pll/req_ana/req_dig. `ST_WAIT_GATE`→`ST_PLL_HOLD`/`ST_ANA_HOLD` on req_pll/req_ana. `ST_ANA_HOLD`→`ST_PLL_HOLD` on req_pll. `ST_ANA_HOLD`→`ST_WAIT_GATE` after ANA_RST_CYCLES. `ST_PLL_HOLD`→`ST_WAIT_GATE` after PLL_PD_CYCLES.

Top module: `tx_rst_seq`

## Requirements
- R1: While arst_n is low, and at once when it falls (no clock edge needed), cal_rst, pll_pd, ana_rst and dig_rst are all 1 and tx_ready is 0.
- R2: With CAL_PLL_FIRST=0, cal_rst stays high for exactly CAL_RST_CYCLES (at least 2) clock cycles after arst_n rises, counting the cycle in which it rises.
- R3: pll_pd stays high for at least PLL_PD_CYCLES cycles after arst_n rises, and ana_rst falls in the same cycle as pll_pd.
- R4: With CAL_PLL_FIRST=0, pll_pd is high for max(PLL_PD_CYCLES, CAL_RST_CYCLES+1) cycles, so it is released after cal_rst. With CAL_PLL_FIRST=1, pll_pd is high for PLL_PD_CYCLES cycles and cal_rst for max(CAL_RST_CYCLES, PLL_PD_CYCLES+1) cycles, so the PLL is powered before calibration is released.
- R5: dig_rst falls on the DIG_HOLD_CYCLES-th consecutive clock edge at which the synchronized gate (pll_pd low, lock high, busy low) is true. Counting the two synchronizer stages, dig_rst is high for DIG_HOLD_CYCLES+1 cycles after the inputs settle. It stays high for as long as the gate stays false.
- R6: If lock drops for even one cycle before the hold completes, the hold count restarts from zero.
- R7: Release happens whether busy falls before lock rises or after it.
- R8: A req_pll pulse in ST_READY raises pll_pd, ana_rst and dig_rst on the next cycle. pll_pd and ana_rst are held for PLL_PD_CYCLES cycles, then the gate hold applies.
- R9: A req_ana pulse in ST_READY raises ana_rst and dig_rst, not pll_pd. ana_rst is held for ANA_RST_CYCLES cycles, then the gate hold applies.
- R10: A req_dig pulse in ST_READY raises only dig_rst, which then waits for the gate hold.
- R11: When requests arrive together, req_pll wins over req_ana and req_ana wins over req_dig. Requests are ignored during ST_RST_ALL and ST_SPLIT.
- R12: tx_ready rises one cycle after dig_rst falls, and it is 0 in any cycle in which dig_rst is 1.
- R13: At all times, pll_pd=1 implies ana_rst=1, ana_rst=1 implies dig_rst=1, and cal_rst=1 implies dig_rst=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| arst_n | input | 1 | Global asynchronous reset, active low |
| pll_lock_a | input | 1 | PLL lock status, asynchronous |
| cal_busy_a | input | 1 | Calibration busy status, asynchronous |
| req_pll | input | 1 | Request a PLL reset (one-cycle pulse) |
| req_ana | input | 1 | Request an analog-section reset |
| req_dig | input | 1 | Request a digital-section reset |
| cal_rst | output | 1 | Calibration-engine reset |
| pll_pd | output | 1 | PLL power-down |
| ana_rst | output | 1 | Transmit analog reset |
| dig_rst | output | 1 | Transmit digital reset |
| tx_ready | output | 1 | Transmitter out of reset |

## Verification
The bench bounces lock partway through the gate hold. A design that does not restart its hold counter would release digital reset about five cycles early. It holds busy high long after lock is stable, and in another test raises lock long after busy has fallen. A gate that latched either condition, or that ignored one, would release at the wrong time in one of these orders. It runs both release orders of PLL power-down and calibration reset on two instances, and an inverted order parameter shows up as swapped hold lengths. It also fires requests during the power-up phases and several requests at once. A design with the wrong priority, or one that accepted a request too early, would change the measured hold lengths.

// File: rtl/tx_rst_pkg.sv
package tx_rst_pkg;

    typedef enum logic [2:0] {
        ST_RST_ALL   = 3'd0,
        ST_SPLIT     = 3'd1,
        ST_WAIT_GATE = 3'd2,
        ST_READY     = 3'd3,
        ST_ANA_HOLD  = 3'd4,
        ST_PLL_HOLD  = 3'd5
    } tx_rst_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tx_rst_sync.sv
module tx_rst_sync #(
    parameter int             W       = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d_a,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d_a[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/tx_rst_cnt.sv
module tx_rst_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && (cnt != '1)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tx_rst_seq.sv
module tx_rst_seq
    import tx_rst_pkg::*;
#(
    parameter int CAL_RST_CYCLES  = 2,
    parameter int PLL_PD_CYCLES   = 100,
    parameter int ANA_RST_CYCLES  = 8,
    parameter int DIG_HOLD_CYCLES = 64,
    parameter bit CAL_PLL_FIRST   = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pll_lock_a,
    input  logic cal_busy_a,
    input  logic req_pll,
    input  logic req_ana,
    input  logic req_dig,
    output logic cal_rst,
    output logic pll_pd,
    output logic ana_rst,
    output logic dig_rst,
    output logic tx_ready
);
    localparam int CAL_LEN    = max2(CAL_RST_CYCLES, 2);
    localparam int PD_LEN     = max2(PLL_PD_CYCLES, 1);
    localparam int ANA_LEN    = max2(ANA_RST_CYCLES, 1);
    localparam int HOLD_LEN   = max2(DIG_HOLD_CYCLES, 1);
    localparam int FIRST_LEN  = CAL_PLL_FIRST ? PD_LEN : CAL_LEN;
    localparam int SECOND_LEN = CAL_PLL_FIRST ? max2(CAL_LEN - PD_LEN, 1)
                                              : max2(PD_LEN - CAL_LEN, 1);
    localparam int CNT_MAX    = max2(max2(FIRST_LEN, SECOND_LEN),
                                     max2(max2(PD_LEN, ANA_LEN), HOLD_LEN));
    localparam int CW         = $clog2(CNT_MAX + 1);

    localparam logic [CW-1:0] FIRST_END  = CW'(FIRST_LEN - 1);
    localparam logic [CW-1:0] SECOND_END = CW'(SECOND_LEN - 1);
    localparam logic [CW-1:0] PD_END     = CW'(PD_LEN - 1);
    localparam logic [CW-1:0] ANA_END    = CW'(ANA_LEN - 1);
    localparam logic [CW-1:0] HOLD_END   = CW'(HOLD_LEN - 1);

    tx_rst_state_e state_q, state_d;
    logic [CW-1:0] phase_cnt, gate_cnt;
    logic [1:0]    stat_s;
    logic          lock_s, busy_s;
    logic          gate_ok, gate_en, gate_done;
    logic          ready_q;

    // lock resets low, busy resets high: the gate starts closed
    tx_rst_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_a    ({cal_busy_a, pll_lock_a}),
        .q      (stat_s)
    );
    assign lock_s = stat_s[0];
    assign busy_s = stat_s[1];

    // cycles spent in the current state
    tx_rst_cnt #(.W(CW)) u_phase (
        .clk    (clk),
        .arst_n (arst_n),
        .clr    (state_d != state_q),
        .en     (1'b1),
        .cnt    (phase_cnt)
    );

    // consecutive cycles with the gate true
    assign gate_ok   = !pll_pd && lock_s && !busy_s;
    assign gate_en   = (state_q == ST_WAIT_GATE) && gate_ok;
    assign gate_done = gate_en && (gate_cnt == HOLD_END);

    tx_rst_cnt #(.W(CW)) u_gate (
        .clk    (clk),
        .arst_n (arst_n),
        .clr    (!gate_en),
        .en     (gate_en),
        .cnt    (gate_cnt)
    );

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_RST_ALL;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ready_q <= (state_q == ST_READY);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RST_ALL: begin
                if (phase_cnt == FIRST_END) state_d = ST_SPLIT;
            end
            ST_SPLIT: begin
                if (phase_cnt == SECOND_END) state_d = ST_WAIT_GATE;
            end
            ST_WAIT_GATE: begin
                if (req_pll)        state_d = ST_PLL_HOLD;
                else if (req_ana)   state_d = ST_ANA_HOLD;
                else if (gate_done) state_d = ST_READY;
            end
            ST_READY: begin
                if (req_pll)      state_d = ST_PLL_HOLD;
                else if (req_ana) state_d = ST_ANA_HOLD;
                else if (req_dig) state_d = ST_WAIT_GATE;
            end
            ST_ANA_HOLD: begin
                if (req_pll)                    state_d = ST_PLL_HOLD;
                else if (phase_cnt == ANA_END)  state_d = ST_WAIT_GATE;
            end
            ST_PLL_HOLD: begin
                if (phase_cnt == PD_END) state_d = ST_WAIT_GATE;
            end
            default: state_d = ST_RST_ALL;
        endcase
    end

    // outputs
    always_comb begin
        cal_rst = 1'b1;
        pll_pd  = 1'b1;
        ana_rst = 1'b1;
        dig_rst = 1'b1;
        unique case (state_q)
            ST_RST_ALL: ;
            ST_SPLIT: begin
                cal_rst = CAL_PLL_FIRST;
                pll_pd  = !CAL_PLL_FIRST;
                ana_rst = !CAL_PLL_FIRST;
            end
            ST_WAIT_GATE: begin
                cal_rst = 1'b0;
                pll_pd  = 1'b0;
                ana_rst = 1'b0;
            end
            ST_READY: begin
                cal_rst = 1'b0;
                pll_pd  = 1'b0;
                ana_rst = 1'b0;
                dig_rst = 1'b0;
            end
            ST_ANA_HOLD: begin
                cal_rst = 1'b0;
                pll_pd  = 1'b0;
            end
            ST_PLL_HOLD: begin
                cal_rst = 1'b0;
            end
            default: ;
        endcase
    end

    assign tx_ready = ready_q && !dig_rst;

endmodule

// File: rtl/tx_rst_seq_chk.sv
module tx_rst_seq_chk #(
    parameter bit CAL_PLL_FIRST = 1'b0
) (
    input logic clk,
    input logic arst_n,
    input logic req_pll,
    input logic req_ana,
    input logic req_dig,
    input logic cal_rst,
    input logic pll_pd,
    input logic ana_rst,
    input logic dig_rst,
    input logic tx_ready
);
    // R13: reset hierarchy
    p_pd_needs_ana_r13: assert property (@(posedge clk) disable iff (!arst_n)
        pll_pd |-> ana_rst);
    p_ana_needs_dig_r13: assert property (@(posedge clk) disable iff (!arst_n)
        ana_rst |-> dig_rst);
    p_cal_needs_dig_r13: assert property (@(posedge clk) disable iff (!arst_n)
        cal_rst |-> dig_rst);

    // R2: calibration reset held at least two cycles
    p_cal_min_r2: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(cal_rst) |-> $past(cal_rst, 2));

    // R5: digital reset leaves only with PLL up and calibration released
    p_dig_gated_r5: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(dig_rst) |-> (!pll_pd && !cal_rst));

    // R4: release order
    if (CAL_PLL_FIRST) begin : g_pll_first
        p_order_r4: assert property (@(posedge clk) disable iff (!arst_n)
            $fell(cal_rst) |-> !pll_pd);
    end else begin : g_cal_first
        p_order_r4: assert property (@(posedge clk) disable iff (!arst_n)
            $fell(pll_pd) |-> !cal_rst);
    end

    // R12: ready follows digital release by one cycle
    p_ready_after_dig_r12: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(tx_ready) |-> ($past(dig_rst, 2) && !$past(dig_rst)));

    // R8: PLL request from ready
    p_pll_req_r8: assert property (@(posedge clk) disable iff (!arst_n)
        (tx_ready && req_pll) |=> (pll_pd && ana_rst && dig_rst));

    // R10: digital request from ready touches only digital reset
    p_dig_req_r10: assert property (@(posedge clk) disable iff (!arst_n)
        (tx_ready && req_dig && !req_pll && !req_ana) |=> (dig_rst && !ana_rst && !pll_pd));
endmodule

bind tx_rst_seq tx_rst_seq_chk #(.CAL_PLL_FIRST(CAL_PLL_FIRST)) u_chk (
    .clk      (clk),
    .arst_n   (arst_n),
    .req_pll  (req_pll),
    .req_ana  (req_ana),
    .req_dig  (req_dig),
    .cal_rst  (cal_rst),
    .pll_pd   (pll_pd),
    .ana_rst  (ana_rst),
    .dig_rst  (dig_rst),
    .tx_ready (tx_ready)
);

// File: tb/sim_tx_rst_seq.sv
module sim_tx_rst_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CAL_N  = 3;
    localparam int PD_N   = 10;
    localparam int ANA_N  = 4;
    localparam int HOLD_N = 6;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic lock = 1'b0, busy = 1'b1;
    logic rq_pll = 1'b0, rq_ana = 1'b0, rq_dig = 1'b0;
    logic cal0, pd0, ana0, dig0, rdy0;
    logic cal1, pd1, ana1, dig1, rdy1;

    int checks = 0, failures = 0;
    int c_cal0, c_pd0, c_ana0, c_dig0, c_rdy0, c_cal1, c_pd1, c_viol;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_rst_seq #(.CAL_RST_CYCLES(CAL_N), .PLL_PD_CYCLES(PD_N), .ANA_RST_CYCLES(ANA_N),
                 .DIG_HOLD_CYCLES(HOLD_N), .CAL_PLL_FIRST(1'b0)) u0 (
        .clk(clk), .arst_n(arst_n), .pll_lock_a(lock), .cal_busy_a(busy),
        .req_pll(rq_pll), .req_ana(rq_ana), .req_dig(rq_dig),
        .cal_rst(cal0), .pll_pd(pd0), .ana_rst(ana0), .dig_rst(dig0), .tx_ready(rdy0));

    tx_rst_seq #(.CAL_RST_CYCLES(CAL_N), .PLL_PD_CYCLES(PD_N), .ANA_RST_CYCLES(ANA_N),
                 .DIG_HOLD_CYCLES(HOLD_N), .CAL_PLL_FIRST(1'b1)) u1 (
        .clk(clk), .arst_n(arst_n), .pll_lock_a(lock), .cal_busy_a(busy),
        .req_pll(rq_pll), .req_ana(rq_ana), .req_dig(rq_dig),
        .cal_rst(cal1), .pll_pd(pd1), .ana_rst(ana1), .dig_rst(dig1), .tx_ready(rdy1));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        c_cal0 = 0; c_pd0 = 0; c_ana0 = 0; c_dig0 = 0; c_rdy0 = 0;
        c_cal1 = 0; c_pd1 = 0; c_viol = 0;
    endtask

    // sample n cycles starting at the current negedge, ending on a negedge
    task automatic sample_n(input int n);
        for (int i = 0; i < n; i++) begin
            #1;
            if (cal0) c_cal0++;
            if (pd0)  c_pd0++;
            if (ana0) c_ana0++;
            if (dig0) c_dig0++;
            if (rdy0) c_rdy0++;
            if (cal1) c_cal1++;
            if (pd1)  c_pd1++;
            if ((pd0 && !ana0) || (ana0 && !dig0) || (cal0 && !dig0) ||
                (pd1 && !ana1) || (ana1 && !dig1) || (cal1 && !dig1)) c_viol++;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input bit p, input bit a, input bit d);
        rq_pll = p; rq_ana = a; rq_dig = d;
        @(negedge clk);
        rq_pll = 1'b0; rq_ana = 1'b0; rq_dig = 1'b0;
    endtask

    task automatic t_power_up();
        #1;
        chk("R1 cal_rst in reset", cal0, 1);
        chk("R1 pll_pd in reset", pd0, 1);
        chk("R1 ana_rst in reset", ana0, 1);
        chk("R1 dig_rst in reset", dig0, 1);
        chk("R1 tx_ready in reset", rdy0, 0);
        repeat (3) @(negedge clk);
        arst_n = 1'b1;
        clr_counts();
        sample_n(30);
        chk("R2 cal_rst length", c_cal0, CAL_N);
        chk("R3 pll_pd length", c_pd0, PD_N);
        chk("R3 ana_rst with pll_pd", c_ana0, PD_N);
        chk("R4 pll-first pll_pd length", c_pd1, PD_N);
        chk("R4 pll-first cal_rst length", c_cal1, PD_N + 1);
        chk("R5 dig_rst held while gate false", c_dig0, 30);
        chk("R13 hierarchy during power-up", c_viol, 0);
    endtask

    task automatic t_gate_release();
        lock = 1'b1; busy = 1'b0;
        @(negedge clk);
        clr_counts();
        sample_n(20);
        chk("R5 dig_rst release time", c_dig0, HOLD_N + 1);
        chk("R12 tx_ready one cycle later", c_rdy0, 20 - (HOLD_N + 1) - 1);
    endtask

    task automatic t_req_dig();
        pulse(1'b0, 1'b0, 1'b1);
        clr_counts();
        sample_n(20);
        chk("R10 dig_rst length", c_dig0, HOLD_N);
        chk("R10 ana_rst untouched", c_ana0, 0);
        chk("R10 pll_pd untouched", c_pd0, 0);
        chk("R12 tx_ready drops and returns", c_rdy0, 20 - HOLD_N - 1);
    endtask

    task automatic t_req_ana();
        pulse(1'b0, 1'b1, 1'b0);
        clr_counts();
        sample_n(20);
        chk("R9 ana_rst length", c_ana0, ANA_N);
        chk("R9 dig_rst length", c_dig0, ANA_N + HOLD_N);
        chk("R9 pll_pd untouched", c_pd0, 0);
        chk("R9 tx_ready", c_rdy0, 20 - ANA_N - HOLD_N - 1);
    endtask

    task automatic t_req_pll();
        pulse(1'b1, 1'b0, 1'b0);
        clr_counts();
        sample_n(24);
        chk("R8 pll_pd length", c_pd0, PD_N);
        chk("R8 ana_rst length", c_ana0, PD_N);
        chk("R8 dig_rst length", c_dig0, PD_N + HOLD_N);
        chk("R8 cal_rst untouched", c_cal0, 0);
        chk("R13 hierarchy during PLL request", c_viol, 0);
    endtask

    task automatic t_priority();
        pulse(1'b1, 1'b0, 1'b1);
        clr_counts();
        sample_n(24);
        chk("R11 pll beats dig", c_pd0, PD_N);
        pulse(1'b0, 1'b1, 1'b1);
        clr_counts();
        sample_n(20);
        chk("R11 ana beats dig", c_ana0, ANA_N);
        chk("R11 ana beats dig, no pll", c_pd0, 0);
    endtask

    task automatic t_bounce();
        lock = 1'b0;
        pulse(1'b0, 1'b0, 1'b1);
        clr_counts();
        sample_n(8);
        chk("R5 dig_rst held with lock low", c_dig0, 8);
        lock = 1'b1;
        repeat (4) @(negedge clk);
        lock = 1'b0;
        @(negedge clk);
        lock = 1'b1;
        @(negedge clk);
        clr_counts();
        sample_n(20);
        chk("R6 hold restarts after lock drop", c_dig0, HOLD_N + 1);
        chk("R7 lock rising after busy low", c_rdy0, 20 - (HOLD_N + 1) - 1);
    endtask

    task automatic t_busy_late();
        busy = 1'b1;
        pulse(1'b0, 1'b0, 1'b1);
        clr_counts();
        sample_n(15);
        chk("R7 dig_rst held while busy", c_dig0, 15);
        busy = 1'b0;
        @(negedge clk);
        clr_counts();
        sample_n(20);
        chk("R7 busy falling after lock", c_dig0, HOLD_N + 1);
    endtask

    task automatic t_reset_ignore();
        arst_n = 1'b0;
        #1;
        chk("R1 async entry dig_rst", dig0, 1);
        chk("R1 async entry pll_pd", pd0, 1);
        chk("R1 async entry tx_ready", rdy0, 0);
        @(negedge clk);
        @(negedge clk);
        arst_n = 1'b1;
        clr_counts();
        sample_n(1);
        rq_pll = 1'b1; rq_ana = 1'b1;
        sample_n(5);
        rq_pll = 1'b0; rq_ana = 1'b0;
        sample_n(24);
        chk("R11 requests ignored, cal_rst", c_cal0, CAL_N);
        chk("R11 requests ignored, pll_pd", c_pd0, PD_N);
        chk("R11 requests ignored, dig_rst", c_dig0, PD_N + HOLD_N);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        t_power_up();
        t_gate_release();
        t_req_dig();
        t_req_ana();
        t_req_pll();
        t_priority();
        t_bounce();
        t_busy_late();
        t_reset_ignore();
        finish_run();
    end
endmodule